// File: doc/BRIEF.md
# Battery Pack Protection Flag Register

This block is the protection status and control register of a battery-pack controller. Four fault indications arrive from the analog comparators: cell overvoltage, cell undervoltage, overcurrent while charging, and overcurrent while discharging. Each one is latched into a sticky flag. A flag stays set until the host clears it with a register write. Two host-writable enable bits allow or forbid charging and discharging.

The block drives two registered, active-high FET-off outputs, one for charge and one for discharge. Each output combines its enable bit with the live fault conditions that guard that path. The current level of each output is reflected back as a read-only bit in the same register. A wake event, marking the return from sleep to active mode, turns both paths back on.

The host reaches the register through an address / data / strobe port, with a one-cycle registered read. Everything lives in one 8-bit register with this layout:

| Bit | Function |
|-----|----------|
| 7 | overvoltage flag |
| 6 | undervoltage flag |
| 5 | charge overcurrent flag |
| 4 | discharge overcurrent flag |
| 3 | charge-off mirror |
| 2 | discharge-off mirror |
| 1 | charge enable |
| 0 | discharge enable |

Top module: `prot_flag_reg`

## Requirements
- R1: A fault input that is high at a clock edge sets its flag at that edge. The fault-to-flag mapping is: `flt_ov` to bit 7, `flt_uv` to bit 6, `flt_coc` to bit 5, `flt_doc` to bit 4.
- R2: A set flag stays set after its fault input drops. Only a register write with a 0 in that flag's bit clears it; a write with a 1 in that bit leaves the flag unchanged.
- R3: If a fault is present in the same cycle as a host write that would clear its flag, the flag ends up set.
- R4: While charge enable (bit 1) is 0, `chg_off` is 1 from the next cycle on. While discharge enable (bit 0) is 0, `dsg_off` is 1 from the next cycle on. Fault inputs do not change this.
- R5: A live `flt_ov` or `flt_coc` forces `chg_off` to 1 in the next cycle. A live `flt_uv` or `flt_doc` forces `dsg_off` to 1 in the next cycle. With its enable at 1 and none of its guarding faults live, an output is 0 in the next cycle.
- R6: A one-cycle `wake` pulse sets both enable bits to 1. This takes priority over a host write in the same cycle.
- R7: Bit 3 of the register reads back the level of `chg_off`, and bit 2 reads back the level of `dsg_off`. Host writes to these two bits have no effect.
- R8: While `rst` is high:
  - all four flags are 0;
  - both enable bits are 1;
  - both FET-off outputs are 1;
  - `rd_data` is 0.
- R9: `rd_en` at a clock edge loads `rd_data` with the register value at that edge when `addr` equals `REG_ADDR`, and with 0 for any other address. Without `rd_en`, `rd_data` holds its value. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| addr | input | ADDR_W | register address for reads and writes |
| wr_en | input | 1 | write strobe |
| wr_data | input | 8 | write data |
| rd_en | input | 1 | read strobe |
| rd_data | output | 8 | registered read data |
| flt_ov | input | 1 | live overvoltage indication |
| flt_uv | input | 1 | live undervoltage indication |
| flt_coc | input | 1 | live charge overcurrent indication |
| flt_doc | input | 1 | live discharge overcurrent indication |
| wake | input | 1 | sleep-to-active transition pulse |
| chg_off | output | 1 | charge FET off, active high |
| dsg_off | output | 1 | discharge FET off, active high |

## Verification
The bench builds the block with the default 4-bit address and places the register at address 10, not at 0. That choice makes all sixteen addresses small enough to sweep. It also means a decoder that ignores the address, or matches only address 0, will return or corrupt data somewhere in that sweep.

With 4 fault lines and 2 enable bits, there are 64 combinations, and the bench drives every one of them. For each combination it computes both FET outputs, the latched flags and the mirror bits arithmetically from the requirements.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int REG_W  = 8;
  localparam int N_FLT  = 4;
  localparam int B_OV   = 7;
  localparam int B_UV   = 6;
  localparam int B_COC  = 5;
  localparam int B_DOC  = 4;
  localparam int B_CMIR = 3;
  localparam int B_DMIR = 2;
  localparam int B_CEN  = 1;
  localparam int B_DEN  = 0;
  localparam int FLT_LO = B_DOC;
  localparam int FLT_HI = B_OV;
  typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/prot_fault_bank.sv
module prot_fault_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fault_i,
  input  logic         we,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr;
    assign clr = we & ~wr_bits[i];

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= fault_i[i] | (flag_q[i] & ~clr);
    end

    // R1
    a_r1_fault_sets: assert property (@(posedge clk) disable iff (rst)
      fault_i[i] |=> flag_q[i]);
    // R2: holds without a zero write
    a_r2_flag_holds: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !(we && !wr_bits[i])) |=> flag_q[i]);
    // R2: a zero write clears when no fault is live
    a_r2_flag_clears: assert property (@(posedge clk) disable iff (rst)
      (!fault_i[i] && we && !wr_bits[i]) |=> !flag_q[i]);
    // R3
    a_r3_fault_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (fault_i[i] && we && !wr_bits[i]) |=> flag_q[i]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/prot_enable_ctrl.sv
module prot_enable_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wake,
  input  logic we,
  input  logic ce_wr,
  input  logic de_wr,
  output logic ce_o,
  output logic de_o
);
  logic ce_q, de_q;

  always_ff @(posedge clk) begin
    if (rst || wake) begin
      ce_q <= 1'b1;
      de_q <= 1'b1;
    end else if (we) begin
      ce_q <= ce_wr;
      de_q <= de_wr;
    end
  end

  // R6
  a_r6_wake_enables: assert property (@(posedge clk) disable iff (rst)
    wake |=> (ce_q && de_q));

  assign ce_o = ce_q;
  assign de_o = de_q;
endmodule

// File: rtl/prot_fet_chan.sv
module prot_fet_chan (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic block,
  output logic off_o
);
  logic off_q;

  always_ff @(posedge clk) begin
    if (rst) off_q <= 1'b1;
    else     off_q <= ~en | block;
  end

  // R4
  a_r4_disabled_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> off_q);
  // R5: a live fault forces the FET off
  a_r5_blocked_off: assert property (@(posedge clk) disable iff (rst)
    block |=> off_q);
  // R5: enabled and clear turns the FET on
  a_r5_clear_on: assert property (@(posedge clk) disable iff (rst)
    (en && !block) |=> !off_q);

  assign off_o = off_q;
endmodule

// File: rtl/prot_flag_reg.sv
module prot_flag_reg
  import prot_pkg::*;
#(
  parameter int               ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic              flt_ov,
  input  logic              flt_uv,
  input  logic              flt_coc,
  input  logic              flt_doc,
  input  logic              wake,
  output logic              chg_off,
  output logic              dsg_off
);
  localparam int N_CH = 2;

  logic             sel, reg_we;
  logic [N_FLT-1:0] fault_vec, flags;
  logic             ce, de;
  logic [N_CH-1:0]  ch_en, ch_block, ch_off;
  reg_t             view;
  reg_t             rd_q;

  assign sel    = (addr == REG_ADDR);
  assign reg_we = wr_en & sel;

  assign fault_vec[B_OV-FLT_LO]  = flt_ov;
  assign fault_vec[B_UV-FLT_LO]  = flt_uv;
  assign fault_vec[B_COC-FLT_LO] = flt_coc;
  assign fault_vec[B_DOC-FLT_LO] = flt_doc;

  prot_fault_bank #(.N(N_FLT)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .fault_i (fault_vec),
    .we      (reg_we),
    .wr_bits (wr_data[FLT_HI:FLT_LO]),
    .flags_o (flags)
  );

  prot_enable_ctrl u_enables (
    .clk   (clk),
    .rst   (rst),
    .wake  (wake),
    .we    (reg_we),
    .ce_wr (wr_data[B_CEN]),
    .de_wr (wr_data[B_DEN]),
    .ce_o  (ce),
    .de_o  (de)
  );

  // channel 1 = charge path, channel 0 = discharge path
  assign ch_en    = {ce, de};
  assign ch_block = {flt_ov | flt_coc, flt_uv | flt_doc};

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    prot_fet_chan u_chan (
      .clk   (clk),
      .rst   (rst),
      .en    (ch_en[c]),
      .block (ch_block[c]),
      .off_o (ch_off[c])
    );
  end

  assign chg_off = ch_off[1];
  assign dsg_off = ch_off[0];

  always_comb begin
    view                = '0;
    view[FLT_HI:FLT_LO] = flags;
    view[B_CMIR]        = chg_off;
    view[B_DMIR]        = dsg_off;
    view[B_CEN]         = ce;
    view[B_DEN]         = de;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= sel ? view : '0;
  end

  assign rd_data = rd_q;

  // R7: mirror bits follow the output pins
  a_r7_mirror_chg: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel) |=> (rd_data[B_CMIR] == $past(chg_off)));
  a_r7_mirror_dsg: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel) |=> (rd_data[B_DMIR] == $past(dsg_off)));
  // R9
  a_r9_other_addr_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sel) |=> (rd_data == '0));
  a_r9_read_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/prot_flag_reg_bench.sv
`timescale 1ns/1ps
module prot_flag_reg_bench;
  localparam int         ADDR_W = 4;
  localparam logic [3:0] RA     = 4'hA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        flt_ov = 1'b0, flt_uv = 1'b0, flt_coc = 1'b0, flt_doc = 1'b0;
  logic        wake = 1'b0;
  logic        chg_off, dsg_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prot_flag_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) u_prot_flag_reg (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .flt_ov(flt_ov), .flt_uv(flt_uv),
    .flt_coc(flt_coc), .flt_doc(flt_doc), .wake(wake),
    .chg_off(chg_off), .dsg_off(dsg_off)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_faults(input logic [3:0] f);
    {flt_ov, flt_uv, flt_coc, flt_doc} = f;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       ce, de, ec, ed;

    // R8: state during reset
    tick(); tick();
    check("R8 chg_off in reset", {7'b0, chg_off}, 8'h01);
    check("R8 dsg_off in reset", {7'b0, dsg_off}, 8'h01);
    check("R8 rd_data in reset", rd_data, 8'h00);
    rst = 1'b0;
    tick();
    check("R5 outputs on after reset", {6'b0, chg_off, dsg_off}, 8'h00);
    rd(RA, v);
    check("R8 register after reset", v, 8'h03);

    // R1 R2 R4 R5 R7: every fault pattern under every enable setting
    for (int e = 0; e < 4; e++) begin
      for (int f = 0; f < 16; f++) begin
        ce = e[1]; de = e[0];
        wr(RA, {6'b0, ce, de});
        set_faults(f[3:0]);
        tick();
        ec = ~ce | f[3] | f[1];
        ed = ~de | f[2] | f[0];
        check("R4/R5 chg_off", {7'b0, chg_off}, {7'b0, ec});
        check("R4/R5 dsg_off", {7'b0, dsg_off}, {7'b0, ed});
        set_faults(4'b0);
        tick();
        rd(RA, v);
        check("R1/R7 sticky flags and mirrors", v, {f[3:0], ~ce, ~de, ce, de});
        wr(RA, {4'hF, 2'b00, ce, de});
        rd(RA, v);
        check("R2 write of ones keeps flags", v, {f[3:0], ~ce, ~de, ce, de});
      end
    end
    wr(RA, 8'h03);
    tick();

    // R3: fault and clearing write in the same cycle
    set_faults(4'b1000);
    wr(RA, 8'h03);
    set_faults(4'b0);
    rd(RA, v);
    check("R3 fault wins over clear", v, 8'h8B);
    wr(RA, 8'h03);
    rd(RA, v);
    check("R2 zero write clears flag", v, 8'h03);

    // R7: writes to mirror bits ignored
    wr(RA, 8'h0F);
    rd(RA, v);
    check("R7 mirror write ignored", v, 8'h03);

    // R6: wake restores enables
    wr(RA, 8'h00);
    tick();
    check("R4 both off when disabled", {6'b0, chg_off, dsg_off}, 8'h03);
    wake = 1'b1; tick(); wake = 1'b0;
    tick();
    rd(RA, v);
    check("R6 wake sets enables", v, 8'h03);
    check("R6 outputs on after wake", {6'b0, chg_off, dsg_off}, 8'h00);
    wr(RA, 8'h00);
    wake = 1'b1;
    wr(RA, 8'h00);
    wake = 1'b0;
    tick();
    rd(RA, v);
    check("R6 wake beats write", v, 8'h03);

    // R9: address decoding
    set_faults(4'b1000); tick(); set_faults(4'b0); tick();
    for (int a = 0; a < 16; a++) begin
      if (a[3:0] != RA) begin
        rd(a[3:0], v);
        check("R9 other address reads zero", v, 8'h00);
        wr(a[3:0], 8'h00);
      end
    end
    rd(RA, v);
    check("R9 other-address writes ignored", v, 8'h83);
    addr = 4'h0;
    tick(); tick();
    check("R9 rd_data holds", rd_data, 8'h83);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule